// File: doc/BRIEF.md
# Synchronised SPWM Group Controller

This block drives a group of four or six sinusoidal PWM channels from one carrier counter. All channels share the carrier length and one duty table. Each channel has its own starting position in that table, which sets its phase relative to the others. The block provides a table position for every channel. An external table returns the raw duty for that position in the same cycle. Each raw duty then passes through a scaling stage and a dead-band clamp. The conditioned value is compared against the shared carrier count, and the result is a registered output bit per channel.

A single group enable starts every channel on the same clock edge. A programmable carrier-period count can end the group automatically once that many carrier periods have been produced, after which a done flag stays high. A separate halt input freezes every output at the level it has at that moment. When halt is released, a fresh sine period starts from each channel's start position. Several groups are built by instantiating the block once per group, so every group has its own round and halt controls.

Top module: `spwm_grp_ctrl`

## Requirements
- R1: While `grp_en` is low, and after reset, every `pwm_out` bit is 0, `round_done` is 0 and the carrier-period count is cleared.
- R2: On the first rising edge with `grp_en` high, all outputs stay 0. From the second edge on, every channel runs carriers of `period` cycles. Within each carrier a channel is high for the first D cycles and low for the rest, where D is its conditioned duty.
- R3: While idle, `tbl_idx` of channel c (bits c*IW upward) equals that channel's `start_idx` field. At the end of each carrier the index steps by one, and it returns to 0 after the value `tbl_len`-1.
- R4: `scale_n` = 0 leaves the raw duty untouched. A value n in 1..7 gives floor(raw*n/8).
- R5: With `clamp_en` high and `clamp_lo` < `clamp_hi`, a scaled duty at or below `clamp_lo` gives 0 high cycles. A scaled duty at or above `clamp_hi` gives a high level for the whole carrier.
- R6: When `clamp_lo` >= `clamp_hi`, the clamp has no effect even if `clamp_en` is high.
- R7: A conditioned duty at or above `period` keeps the output high for the whole carrier.
- R8: With `round_num` nonzero, exactly `round_num` carriers are produced. After that every output stays 0 and `round_done` stays 1. A `round_num` of 0 means no limit.
- R9: Dropping `grp_en` and raising it again clears the carrier-period count and `round_done`, so a further `round_num` carriers follow.
- R10: While `halt` is high during operation, every output keeps the level it had when halt arrived, and the carrier count stalls.
- R11: On the first edge after `halt` drops, all outputs are 0. A fresh carrier then begins at every channel's start index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_en | input | 1 | Group enable; low returns the group to idle |
| halt | input | 1 | Emergency freeze of all outputs |
| period | input | DW | Carrier length in clock cycles (at least 1) |
| tbl_len | input | IW+1 | Number of table entries walked (1..2^IW) |
| start_idx | input | NCH*IW | Per-channel start position in the table |
| raw_duty | input | NCH*DW | Per-channel table value for the current `tbl_idx` |
| scale_n | input | 3 | Scale numerator over 8; 0 disables scaling |
| clamp_en | input | 1 | Enables the dead-band clamp |
| clamp_lo | input | DW | Clamp lower limit in cycles |
| clamp_hi | input | DW | Clamp upper limit in cycles |
| round_num | input | RW | Carrier count before auto-stop; 0 = unlimited |
| tbl_idx | output | NCH*IW | Per-channel table position |
| pwm_out | output | NCH | Per-channel modulated output |
| round_done | output | 1 | High once the carrier count is reached |

## Verification
The bench sweeps every scale value across a full table wrap for four phase-shifted channels and counts the high cycles in each carrier. A floor that rounded up, or a phase index that failed to wrap at the table length, would shift those counts. It drives the clamp limits in both orders, including equal limits: a clamp that ignored the limit order would zero or saturate duties it must leave alone. It also stops a run with the round counter, re-enables it, and halts it mid-carrier with mixed output levels. Design faults in these areas would show up as an extra or missing carrier, a stale done flag after re-enable, outputs dropping or advancing during halt, or a restart that resumes the old phase.

// File: rtl/spwm_grp_pkg.sv
package spwm_grp_pkg;
  // scale numerator is applied over 2**SCALE_SHIFT
  localparam int SCALE_SHIFT = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_DONE = 2'd3
  } grp_state_e;
endpackage

// File: rtl/spwm_duty_cond.sv
module spwm_duty_cond
  import spwm_grp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]          raw,
  input  logic [DW-1:0]          period,
  input  logic [SCALE_SHIFT-1:0] scale_n,
  input  logic                   clamp_en,
  input  logic [DW-1:0]          clamp_lo,
  input  logic [DW-1:0]          clamp_hi,
  output logic [DW-1:0]          eff
);
  localparam int PW = DW + SCALE_SHIFT;

  logic [PW-1:0] prod;
  logic [DW-1:0] scaled;
  logic          clamp_on;

  always_comb begin
    prod     = {{SCALE_SHIFT{1'b0}}, raw} * {{DW{1'b0}}, scale_n};
    scaled   = (scale_n == '0) ? raw : prod[PW-1:SCALE_SHIFT];
    clamp_on = clamp_en && (clamp_lo < clamp_hi);
    eff      = scaled;
    if (clamp_on) begin
      if (scaled <= clamp_lo)      eff = '0;
      else if (scaled >= clamp_hi) eff = period;
    end
  end
endmodule

// File: rtl/spwm_phase_idx.sv
module spwm_phase_idx #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [IW-1:0] start,
  input  logic [IW:0]   len,
  output logic [IW-1:0] idx
);
  logic [IW:0] nxt;

  assign nxt = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= start;
    else if (adv)  idx <= (nxt >= len) ? '0 : nxt[IW-1:0];
  end

  // R3: a step never lands on or beyond the table length
  p_idx_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && (len != '0)) |=> ({1'b0, idx} < $past(len)));
endmodule

// File: rtl/spwm_grp_ctrl.sv
module spwm_grp_ctrl
  import spwm_grp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int IW  = 6,
  parameter int RW  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   grp_en,
  input  logic                   halt,
  input  logic [DW-1:0]          period,
  input  logic [IW:0]            tbl_len,
  input  logic [NCH*IW-1:0]      start_idx,
  input  logic [NCH*DW-1:0]      raw_duty,
  input  logic [SCALE_SHIFT-1:0] scale_n,
  input  logic                   clamp_en,
  input  logic [DW-1:0]          clamp_lo,
  input  logic [DW-1:0]          clamp_hi,
  input  logic [RW-1:0]          round_num,
  output logic [NCH*IW-1:0]      tbl_idx,
  output logic [NCH-1:0]         pwm_out,
  output logic                   round_done
);
  generate
    if (NCH != 4 && NCH != 6) begin : g_bad_nch
      $error("spwm_grp_ctrl: NCH must be 4 or 6");
    end
  endgenerate

  grp_state_e    state_q;
  logic [DW-1:0] cnt_q;
  logic [RW-1:0] pulses_q;
  logic [NCH-1:0] pwm_d;
  logic          wrap;
  logic          round_hit;
  logic          load_idx;
  logic          adv_idx;

  assign wrap      = (cnt_q == period - 1'b1);
  assign round_hit = (round_num != '0) && ((pulses_q + 1'b1) == round_num);
  assign load_idx  = !grp_en || (state_q == ST_IDLE) ||
                     ((state_q == ST_HALT) && !halt);
  assign adv_idx   = grp_en && (state_q == ST_RUN) && !halt && wrap;
  assign round_done = (state_q == ST_DONE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] eff;

    spwm_phase_idx #(.IW(IW)) u_idx (
      .clk   (clk),
      .rst   (rst),
      .load  (load_idx),
      .adv   (adv_idx),
      .start (start_idx[c*IW +: IW]),
      .len   (tbl_len),
      .idx   (tbl_idx[c*IW +: IW])
    );

    spwm_duty_cond #(.DW(DW)) u_cond (
      .raw      (raw_duty[c*DW +: DW]),
      .period   (period),
      .scale_n  (scale_n),
      .clamp_en (clamp_en),
      .clamp_lo (clamp_lo),
      .clamp_hi (clamp_hi),
      .eff      (eff)
    );

    assign pwm_d[c] = (cnt_q < eff);
  end

  always_ff @(posedge clk) begin
    if (rst || !grp_en) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      pulses_q <= '0;
      pwm_out  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!halt) state_q <= ST_RUN;
          cnt_q   <= '0;
          pwm_out <= '0;
        end
        ST_RUN: begin
          if (halt) begin
            state_q <= ST_HALT;
          end else begin
            pwm_out <= pwm_d;
            if (wrap) begin
              cnt_q    <= '0;
              pulses_q <= pulses_q + 1'b1;
              if (round_hit) state_q <= ST_DONE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_HALT: begin
          if (!halt) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            pwm_out <= '0;
          end
        end
        ST_DONE: pwm_out <= '0;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: a low enable clears outputs, done flag and carrier count
  p_clear_on_disable_r1: assert property (@(posedge clk) disable iff (rst)
    !grp_en |=> (pwm_out == '0) && !round_done && (pulses_q == '0));

  // R3: idle channels present their start position
  p_start_idx_r3: assert property (@(posedge clk) disable iff (rst)
    !grp_en |=> (tbl_idx == $past(start_idx)));

  // R8: once done has settled the outputs are low
  p_done_low_r8: assert property (@(posedge clk) disable iff (rst)
    (round_done && $past(round_done)) |-> (pwm_out == '0));

  // R8: done appears only when the programmed count is reached
  p_round_count_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(round_done) |-> ((round_num != '0) && (pulses_q == round_num)));

  // R10: halt during operation holds every output level
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (grp_en && halt && (state_q != ST_IDLE)) |=> $stable(pwm_out));

  // R11: the release edge drives all outputs low
  p_release_low_r11: assert property (@(posedge clk) disable iff (rst)
    (grp_en && !halt && (state_q == ST_HALT)) |=> (pwm_out == '0));
endmodule

// File: tb/tb_spwm_grp_ctrl.sv
module tb_spwm_grp_ctrl;
  localparam int CLK_P = 10;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int IW  = 6;
  localparam int RW  = 16;
  localparam int PER = 20;
  localparam int LEN = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              grp_en;
  logic              halt;
  logic [DW-1:0]     period;
  logic [IW:0]       tbl_len;
  logic [NCH*IW-1:0] start_idx;
  logic [NCH*DW-1:0] raw_duty;
  logic [2:0]        scale_n;
  logic              clamp_en;
  logic [DW-1:0]     clamp_lo;
  logic [DW-1:0]     clamp_hi;
  logic [RW-1:0]     round_num;
  logic [NCH*IW-1:0] tbl_idx;
  logic [NCH-1:0]    pwm_out;
  logic              round_done;

  int checks = 0;
  int fails  = 0;
  int starts [NCH] = '{0, 3, 5, 7};
  int g_scale = 0;
  bit g_clen  = 1'b0;
  int g_lo = 0;
  int g_hi = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spwm_grp_ctrl #(.NCH(NCH), .DW(DW), .IW(IW), .RW(RW)) dut (
    .clk(clk), .rst(rst), .grp_en(grp_en), .halt(halt), .period(period),
    .tbl_len(tbl_len), .start_idx(start_idx), .raw_duty(raw_duty),
    .scale_n(scale_n), .clamp_en(clamp_en), .clamp_lo(clamp_lo),
    .clamp_hi(clamp_hi), .round_num(round_num), .tbl_idx(tbl_idx),
    .pwm_out(pwm_out), .round_done(round_done)
  );

  function automatic int tbl_val(int i);
    return i * 3 + 1;
  endfunction

  // external duty table, looked up combinationally
  always_comb begin
    for (int c = 0; c < NCH; c++)
      raw_duty[c*DW +: DW] = DW'(tbl_val(int'(tbl_idx[c*IW +: IW])));
  end

  function automatic int exp_hi(int ch, int k);
    int d;
    d = tbl_val((starts[ch] + k) % LEN);
    if (g_scale != 0) d = (d * g_scale) / 8;
    if (g_clen && (g_lo < g_hi)) begin
      if (d <= g_lo)      d = 0;
      else if (d >= g_hi) d = PER;
    end
    if (d > PER) d = PER;
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_windows(input int nwin, input int k0, input bit zero, input string tag);
    for (int w = 0; w < nwin; w++) begin
      int hc [NCH];
      for (int c = 0; c < NCH; c++) hc[c] = 0;
      for (int s = 0; s < PER; s++) begin
        @(negedge clk);
        for (int c = 0; c < NCH; c++) if (pwm_out[c]) hc[c]++;
      end
      for (int c = 0; c < NCH; c++) begin
        int e;
        e = zero ? 0 : exp_hi(c, k0 + w);
        chk(hc[c] == e, $sformatf("%s ch%0d carrier%0d", tag, c, k0 + w), hc[c], e);
      end
    end
  endtask

  task automatic start_run(input string tag);
    @(negedge clk) grp_en = 1'b1;
    @(negedge clk);
    chk(pwm_out == '0, {tag, " R2 first edge low"}, int'(pwm_out), 0);
  endtask

  task automatic stop_run();
    @(negedge clk) grp_en = 1'b0;
    @(negedge clk);
    chk(pwm_out == '0, "R1 disable outputs", int'(pwm_out), 0);
    chk(round_done == 1'b0, "R1 disable done", int'(round_done), 0);
    for (int c = 0; c < NCH; c++)
      chk(int'(tbl_idx[c*IW +: IW]) == starts[c], "R3 idle index",
          int'(tbl_idx[c*IW +: IW]), starts[c]);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] held;
    logic [NCH-1:0] em;
    rst = 1'b1; grp_en = 1'b0; halt = 1'b0;
    period = DW'(PER); tbl_len = (IW+1)'(LEN);
    for (int c = 0; c < NCH; c++) start_idx[c*IW +: IW] = IW'(starts[c]);
    scale_n = '0; clamp_en = 1'b0; clamp_lo = '0; clamp_hi = '0; round_num = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_out == '0, "R1 reset outputs", int'(pwm_out), 0);
    chk(round_done == 1'b0, "R1 reset done", int'(round_done), 0);
    for (int c = 0; c < NCH; c++)
      chk(int'(tbl_idx[c*IW +: IW]) == starts[c], "R3 reset index",
          int'(tbl_idx[c*IW +: IW]), starts[c]);

    // R2 R3 R4 R7: every scale value across a full table wrap
    for (int n = 0; n < 8; n++) begin
      g_scale = n; scale_n = 3'(n);
      start_run("R4");
      run_windows(LEN + 2, 0, 1'b0, $sformatf("R4 R7 scale%0d", n));
      stop_run();
    end

    // R5: clamp with ordered limits
    g_clen = 1'b1; clamp_en = 1'b1; g_lo = 6; g_hi = 15;
    clamp_lo = 16'd6; clamp_hi = 16'd15;
    for (int n = 0; n < 8; n += 6) begin
      g_scale = n; scale_n = 3'(n);
      start_run("R5");
      run_windows(LEN, 0, 1'b0, $sformatf("R5 clamp scale%0d", n));
      stop_run();
    end

    // R6: equal and reversed limits leave duties alone
    g_scale = 0; scale_n = '0;
    g_lo = 10; g_hi = 10; clamp_lo = 16'd10; clamp_hi = 16'd10;
    start_run("R6");
    run_windows(LEN, 0, 1'b0, "R6 equal limits");
    stop_run();
    g_lo = 15; g_hi = 6; clamp_lo = 16'd15; clamp_hi = 16'd6;
    start_run("R6");
    run_windows(LEN, 0, 1'b0, "R6 reversed limits");
    stop_run();
    g_clen = 1'b0; clamp_en = 1'b0;

    // R8: auto-stop after five carriers
    round_num = 16'd5;
    start_run("R8");
    run_windows(5, 0, 1'b0, "R8 counted");
    chk(round_done == 1'b1, "R8 done set", int'(round_done), 1);
    run_windows(2, 0, 1'b1, "R8 after done");
    chk(round_done == 1'b1, "R8 done held", int'(round_done), 1);
    stop_run();

    // R9: a new enable grants a fresh count
    start_run("R9");
    run_windows(5, 0, 1'b0, "R9 recount");
    chk(round_done == 1'b1, "R9 done again", int'(round_done), 1);
    run_windows(1, 0, 1'b1, "R9 after done");
    stop_run();

    // R8: zero means unlimited
    round_num = '0;
    start_run("R8");
    run_windows(12, 0, 1'b0, "R8 unlimited");
    chk(round_done == 1'b0, "R8 unlimited no done", int'(round_done), 0);
    stop_run();

    // R10 R11: halt mid-carrier, then release
    start_run("R10");
    run_windows(2, 0, 1'b0, "R10 pre-halt");
    repeat (7) @(negedge clk);
    held = pwm_out;
    for (int c = 0; c < NCH; c++) em[c] = (6 < exp_hi(c, 2));
    chk(held == em, "R10 level at halt", int'(held), int'(em));
    halt = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(pwm_out == held, "R10 held level", int'(pwm_out), int'(held));
    end
    halt = 1'b0;
    @(negedge clk);
    chk(pwm_out == '0, "R11 release low", int'(pwm_out), 0);
    run_windows(3, 0, 1'b0, "R11 fresh start");
    stop_run();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule